// File: doc/BRIEF.md
# Serial ADC Link Deserializer and Word Aligner

This block receives one serial data lane from a multi-channel converter link and rebuilds its 12-bit sample words. The lane is sampled on both edges of the forwarded bit clock, so one word arrives over six bit-clock periods. A forwarded frame clock runs at word rate. Its rising edge marks the first bit of every word. The recovered bits are collected in a short history register. A word window is cut from that register at each frame boundary. The window can be shifted by whole bit positions with a bit-slip request.

Before live samples are accepted, the link is trained. The transmitter sends either an alternating bit pattern, which checks the bit-sampling phase, or a half-zeros/half-ones pattern, which checks the word boundary. The block compares every received frame with the expected pattern. It raises a lock flag after a run of good frames. It counts bad frames in a saturating counter. In live mode each recovered word is presented with a one-cycle valid strobe, but only while the link is locked. Bit order on the wire is selectable so that it matches the transmitter.

Top module: `sdes_aligner`

## Requirements
- R1: While rst_ni is low, and after its release until the first word is evaluated, word_o is 0 and valid_o, lock_o and err_cnt_o are all 0.
- R2: sdata_i is sampled on the rising and the falling edge of clk_i. The rising-edge bit is earlier in time. A word is the 12 bits from the rising-edge sample where frame_i is first seen high through the following 5 bit-clock periods. Exactly one word is evaluated every 6 clk_i cycles.
- R3: With msb_first_i = 0, the first bit of a frame in time is word_o[0] and the last is word_o[11].
- R4: With msb_first_i = 1, the first bit of a frame in time is word_o[11] and the last is word_o[0].
- R5: mode_i = 1 selects alternating training. The expected frame in time order is 1,0,1,0,... and starts with 1. The comparison does not depend on msb_first_i.
- R6: mode_i = 2 selects boundary training. The expected frame in time order is six 0 bits followed by six 1 bits. The comparison does not depend on msb_first_i.
- R7: In a training mode, lock_o is set after 4 consecutive evaluated frames match the expected pattern. lock_o keeps its value while mode_i is 0 or 3.
- R8: Any evaluated frame in a training mode that does not match clears lock_o in the same cycle that err_cnt_o counts it, and restarts the run of good frames.
- R9: err_cnt_o increases by exactly 1 for each mismatching training frame and holds at 15 (all ones, ERR_W = 4) once it gets there.
- R10: A one-cycle pulse on slip_i moves the word window one bit earlier in the stream, modulo 12. The move takes effect from the next frame-clock rising edge.
- R11: With mode_i = 0 and lock_o = 1, valid_o is high for exactly one cycle per evaluated frame, and word_o holds that word. With the link unlocked, or in any other mode, valid_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Forwarded bit clock, both edges carry data |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sdata_i | input | 1 | Serial data lane |
| frame_i | input | 1 | Forwarded frame clock, rising edge marks word start |
| mode_i | input | 2 | 0 live, 1 alternating training, 2 boundary training, 3 idle |
| msb_first_i | input | 1 | 1 = first bit in time is the word MSB |
| slip_i | input | 1 | Bit-slip request, one-cycle pulse |
| word_o | output | 12 | Last recovered live word |
| valid_o | output | 1 | One-cycle strobe for a new live word |
| lock_o | output | 1 | Training has confirmed alignment |
| err_cnt_o | output | 4 | Saturating count of mismatching training frames |

## Verification
The assertions check several rules on every cycle. valid_o rises only in live mode on a locked link, and it never lasts two cycles. The error count only steps up by one, and it stays put once saturated. Each counted mismatch leaves the link unlocked. The bench scenarios are needed for the behaviour that depends on what the serial stream holds. These are the bit order of recovered words in both modes, the number of good frames needed for lock, and re-locking after training mismatches. The bench also shows that a misaligned stream is recovered only after a bit-slip request, and that a live stream on an unlocked link produces no valid strobes.

// File: rtl/sdes_pkg.sv
`timescale 1ns/1ps
package sdes_pkg;
  typedef enum logic [1:0] {
    MODE_LIVE   = 2'd0,
    MODE_ALT    = 2'd1,
    MODE_BOUND  = 2'd2,
    MODE_IDLE   = 2'd3
  } link_mode_e;

  function automatic logic is_training(link_mode_e m);
    return (m == MODE_ALT) || (m == MODE_BOUND);
  endfunction
endpackage

// File: rtl/sdes_ddr_capture.sv
`timescale 1ns/1ps
module sdes_ddr_capture #(
  parameter int unsigned HIST_W = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdata_i,
  output logic [HIST_W-1:0] hist_o
);
  logic rise_q, fall_q;
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rise_q <= 1'b0;
    else         rise_q <= sdata_i;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_q <= 1'b0;
    else         fall_q <= sdata_i;
  end

  // newest bit at index 0; rising-edge bit is the older of each pair
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= {hist_q[HIST_W-3:0], rise_q, fall_q};
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/sdes_frame_tracker.sv
`timescale 1ns/1ps
module sdes_frame_tracker #(
  parameter int unsigned WORD_W = 12,
  parameter int unsigned PAIRS  = WORD_W / 2,
  parameter int unsigned OFS_W  = $clog2(WORD_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic             slip_i,
  output logic             eval_o,
  output logic [OFS_W-1:0] offset_o
);
  localparam int unsigned CNT_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  logic             frm_q1, frm_q2, framed_q, slip_pend_q, eval_q;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [OFS_W-1:0] ofs_q;
  logic             start;

  assign start = frm_q1 & ~frm_q2;
  assign cnt_n = start ? '0 :
                 (cnt_q == CNT_W'(PAIRS-1)) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frm_q1      <= 1'b0;
      frm_q2      <= 1'b0;
      framed_q    <= 1'b0;
      slip_pend_q <= 1'b0;
      cnt_q       <= '0;
      ofs_q       <= '0;
      eval_q      <= 1'b0;
    end else begin
      frm_q1 <= frame_i;
      frm_q2 <= frm_q1;
      cnt_q  <= cnt_n;
      eval_q <= (framed_q | start) && (cnt_n == CNT_W'(PAIRS-1));
      if (start) begin
        framed_q    <= 1'b1;
        slip_pend_q <= 1'b0;
        if (slip_pend_q | slip_i)
          ofs_q <= (ofs_q == OFS_W'(WORD_W-1)) ? '0 : ofs_q + 1'b1;
      end else if (slip_i) begin
        slip_pend_q <= 1'b1;
      end
    end
  end

  assign eval_o   = eval_q;
  assign offset_o = ofs_q;
endmodule

// File: rtl/sdes_word_extract.sv
`timescale 1ns/1ps
module sdes_word_extract #(
  parameter int unsigned WORD_W = 12,
  parameter int unsigned HIST_W = 2 * WORD_W - 1,
  parameter int unsigned OFS_W  = $clog2(WORD_W)
) (
  input  logic [HIST_W-1:0] hist_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic              msb_first_i,
  output logic [WORD_W-1:0] window_o,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] win;
  logic [WORD_W-1:0] rev;

  // win[WORD_W-1] is the earliest bit of the frame
  assign win = hist_i[offset_i +: WORD_W];

  always_comb begin
    for (int i = 0; i < WORD_W; i++) rev[i] = win[WORD_W-1-i];
  end

  assign window_o = win;
  assign word_o   = msb_first_i ? win : rev;
endmodule

// File: rtl/sdes_train_check.sv
`timescale 1ns/1ps
module sdes_train_check
  import sdes_pkg::*;
#(
  parameter int unsigned WORD_W   = 12,
  parameter int unsigned LOCK_RUN = 4,
  parameter int unsigned ERR_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eval_i,
  input  link_mode_e        mode_i,
  input  logic [WORD_W-1:0] window_i,
  output logic              lock_o,
  output logic [ERR_W-1:0]  err_cnt_o
);
  localparam int unsigned RUN_W = $clog2(LOCK_RUN + 1);

  logic [WORD_W-1:0] alt_pat, bound_pat, exp_pat;
  logic [RUN_W-1:0]  run_q, run_n;
  logic [ERR_W-1:0]  err_q;
  logic              lock_q, match;

  always_comb begin
    for (int i = 0; i < WORD_W; i++) begin
      alt_pat[i]   = (((WORD_W - 1 - i) % 2) == 0);
      bound_pat[i] = (i < WORD_W / 2);
    end
  end

  assign exp_pat = (mode_i == MODE_ALT) ? alt_pat : bound_pat;
  assign match   = (window_i == exp_pat);
  assign run_n   = (run_q == RUN_W'(LOCK_RUN)) ? run_q : run_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      lock_q <= 1'b0;
      err_q  <= '0;
    end else if (eval_i && is_training(mode_i)) begin
      if (match) begin
        run_q <= run_n;
        if (run_n == RUN_W'(LOCK_RUN)) lock_q <= 1'b1;
      end else begin
        run_q  <= '0;
        lock_q <= 1'b0;
        if (err_q != '1) err_q <= err_q + 1'b1;
      end
    end
  end

  assign lock_o    = lock_q;
  assign err_cnt_o = err_q;
endmodule

// File: rtl/sdes_aligner.sv
`timescale 1ns/1ps
module sdes_aligner
  import sdes_pkg::*;
#(
  parameter int unsigned WORD_W   = 12,
  parameter int unsigned LOCK_RUN = 4,
  parameter int unsigned ERR_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdata_i,
  input  logic              frame_i,
  input  logic [1:0]        mode_i,
  input  logic              msb_first_i,
  input  logic              slip_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              lock_o,
  output logic [ERR_W-1:0]  err_cnt_o
);
  localparam int unsigned HIST_W = 2 * WORD_W - 1;
  localparam int unsigned OFS_W  = $clog2(WORD_W);

  link_mode_e        mode;
  logic [HIST_W-1:0] hist;
  logic [OFS_W-1:0]  offset;
  logic [WORD_W-1:0] window, word;
  logic              eval, lock;
  logic [WORD_W-1:0] word_q;
  logic              valid_q;

  assign mode = link_mode_e'(mode_i);

  sdes_ddr_capture #(.HIST_W(HIST_W)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .sdata_i(sdata_i), .hist_o(hist)
  );

  sdes_frame_tracker #(.WORD_W(WORD_W), .OFS_W(OFS_W)) u_frm (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .slip_i(slip_i),
    .eval_o(eval), .offset_o(offset)
  );

  sdes_word_extract #(.WORD_W(WORD_W), .HIST_W(HIST_W), .OFS_W(OFS_W)) u_ext (
    .hist_i(hist), .offset_i(offset), .msb_first_i(msb_first_i),
    .window_o(window), .word_o(word)
  );

  sdes_train_check #(.WORD_W(WORD_W), .LOCK_RUN(LOCK_RUN), .ERR_W(ERR_W)) u_trn (
    .clk_i(clk_i), .rst_ni(rst_ni), .eval_i(eval), .mode_i(mode),
    .window_i(window), .lock_o(lock), .err_cnt_o(err_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (eval && lock && mode == MODE_LIVE) begin
        word_q  <= word;
        valid_q <= 1'b1;
      end
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
  assign lock_o  = lock;
endmodule

// File: rtl/sdes_aligner_chk.sv
`timescale 1ns/1ps
module sdes_aligner_chk #(
  parameter int unsigned ERR_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             valid_o,
  input logic             lock_o,
  input logic [ERR_W-1:0] err_cnt_o
);
  p_valid_gated_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(lock_o) && $past(mode_i) == 2'd0));

  p_valid_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_err_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_o != $past(err_cnt_o)) |-> (err_cnt_o == $past(err_cnt_o) + 1'b1));

  p_err_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_o == '1) |=> (err_cnt_o == '1));

  p_miss_unlock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_o != $past(err_cnt_o)) |-> !lock_o);

  p_lock_train_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> ($past(mode_i) == 2'd1 || $past(mode_i) == 2'd2));
endmodule

bind sdes_aligner sdes_aligner_chk #(.ERR_W(ERR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .valid_o(valid_o),
  .lock_o(lock_o), .err_cnt_o(err_cnt_o)
);

// File: tb/sdes_aligner_test.sv
`timescale 1ns/1ps
module sdes_aligner_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sdata = 1'b0;
  logic        frame = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        msb_first = 1'b0;
  logic        slip = 1'b0;
  logic [11:0] word;
  logic        valid, lock;
  logic [3:0]  err;

  int checks = 0;
  int fails  = 0;

  sdes_aligner uut (
    .clk_i(clk), .rst_ni(rst_n), .sdata_i(sdata), .frame_i(frame),
    .mode_i(mode), .msb_first_i(msb_first), .slip_i(slip),
    .word_o(word), .valid_o(valid), .lock_o(lock), .err_cnt_o(err)
  );

  always #2.5 clk = ~clk;

  localparam logic [11:0] ALT_STREAM   = 12'hAAA; // bit 11 sent first
  localparam logic [11:0] BOUND_STREAM = 12'h03F;

  // bench serializer state
  logic [11:0] tx_pat = 12'h000;
  logic [11:0] tx_list [8];
  int          list_n = 0;
  int          list_i = 0;
  int          tx_dly = 0;
  logic [11:0] cur = 12'h000;
  logic [31:0] thist = '0;
  int          ph = 5;

  logic [11:0] rx [64];
  int          rx_n = 0;

  function automatic logic [11:0] rev12(logic [11:0] v);
    logic [11:0] r;
    for (int i = 0; i < 12; i++) r[i] = v[11-i];
    return r;
  endfunction

  // stream order: bit 11 first
  function automatic logic [11:0] to_stream(logic [11:0] w, logic msb);
    return msb ? w : rev12(w);
  endfunction

  task automatic emit(logic b);
    thist = {thist[30:0], b};
    sdata = thist[tx_dly];
  endtask

  initial begin
    forever begin
      @(negedge clk); #1.25;
      ph = (ph == 5) ? 0 : ph + 1;
      if (ph == 0) begin
        if (list_i < list_n) begin
          cur = to_stream(tx_list[list_i], msb_first);
          list_i++;
        end else begin
          cur = tx_pat;
        end
      end
      emit(cur[11 - 2*ph]);
      frame = (ph < 3);
      @(posedge clk); #1.25;
      emit(cur[11 - (2*ph + 1)]);
    end
  end

  always @(negedge clk) begin
    if (valid && rx_n < 64) begin
      rx[rx_n] = word;
      rx_n++;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #0.5;
  endtask

  task automatic wait_frames(int n);
    step(n * 6);
  endtask

  task automatic do_reset(logic [1:0] m, logic msb, logic [11:0] pat, int dly);
    @(posedge clk); #0.5;
    rst_n = 1'b0; mode = m; msb_first = msb; tx_pat = pat; tx_dly = dly;
    list_n = 0; list_i = 0;
    step(4);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state;
    @(posedge clk); #0.5;
    rst_n = 1'b0;
    @(negedge clk);
    chk(word == 12'h0 && !valid && !lock && err == 4'h0, "R1 in reset",
        {word, valid, lock, err}, 0);
    step(3);
    rst_n = 1'b1;
    step(2);
    @(negedge clk);
    chk(word == 12'h0 && !valid && !lock && err == 4'h0, "R1 after release",
        {word, valid, lock, err}, 0);
  endtask

  task automatic t_unlocked_live;
    do_reset(2'd0, 1'b0, 12'h5C3, 0);
    rx_n = 0;
    wait_frames(12);
    chk(rx_n == 0, "R11 no valid while unlocked", rx_n, 0);
    chk(!lock, "R7 live mode does not lock", lock, 0);
  endtask

  task automatic t_lock(logic [1:0] m, logic msb, logic [11:0] pat, string req);
    do_reset(m, msb, pat, 0);
    wait_frames(3);
    @(negedge clk);
    chk(!lock, {req, " R7 no lock before 4 frames"}, lock, 0);
    wait_frames(6);
    @(negedge clk);
    chk(lock, {req, " R7 lock after good frames"}, lock, 1);
    chk(err == 4'h0, {req, " R9 no errors on clean pattern"}, err, 0);
  endtask

  task automatic t_live_words(string req);
    logic [11:0] patw;
    int idx;
    patw = msb_first ? tx_pat : rev12(tx_pat);
    @(posedge clk); #0.5;
    mode = 2'd0;
    rx_n = 0;
    wait_frames(10);
    chk(rx_n == 10, "R11 one valid per frame", rx_n, 10);
    chk(lock, "R7 lock held in live mode", lock, 1);
    rx_n = 0;
    list_i = 0;
    list_n = 6;
    wait_frames(12);
    idx = 0;
    while (idx < rx_n && rx[idx] == patw) idx++;
    chk(rx_n >= idx + 6, {req, " R2 word count"}, rx_n, idx + 6);
    for (int k = 0; k < 6; k++) begin
      if (idx + k < rx_n)
        chk(rx[idx+k] == tx_list[k], {req, " word order"}, rx[idx+k], tx_list[k]);
    end
  endtask

  task automatic t_mismatch;
    int e0;
    @(posedge clk); #0.5;
    mode = 2'd1;
    tx_pat = BOUND_STREAM;
    e0 = err;
    wait_frames(3);
    @(negedge clk);
    chk(!lock, "R8 mismatch clears lock", lock, 0);
    chk(err > e0, "R9 mismatch counted", err, e0 + 1);
    wait_frames(20);
    @(negedge clk);
    chk(err == 4'hF, "R9 counter saturates", err, 15);
    @(posedge clk); #0.5;
    tx_pat = ALT_STREAM;
    wait_frames(8);
    @(negedge clk);
    chk(lock, "R7 relock after good run", lock, 1);
    chk(err == 4'hF, "R9 saturated count held", err, 15);
  endtask

  task automatic t_slip;
    int e0;
    do_reset(2'd2, 1'b0, BOUND_STREAM, 11);
    wait_frames(8);
    @(negedge clk);
    chk(!lock, "R10 misaligned stream no lock", lock, 0);
    chk(err != 4'h0, "R10 misaligned stream errors", err, 1);
    @(posedge clk); #0.5;
    slip = 1'b1;
    step(1);
    slip = 1'b0;
    wait_frames(8);
    @(negedge clk);
    chk(lock, "R10 slip restores lock", lock, 1);
    e0 = err;
    wait_frames(4);
    @(negedge clk);
    chk(err == e0, "R10 no errors after slip", err, e0);
  endtask

  initial begin
    t_reset_state();
    t_unlocked_live();
    // LSB-first: alternating training then live words
    t_lock(2'd1, 1'b0, ALT_STREAM, "R5");
    tx_list[0] = 12'h123; tx_list[1] = 12'hABC; tx_list[2] = 12'h800;
    tx_list[3] = 12'h001; tx_list[4] = 12'hFFF; tx_list[5] = 12'h5A4;
    t_live_words("R3");
    t_mismatch();
    // MSB-first: boundary training then live words
    t_lock(2'd2, 1'b1, BOUND_STREAM, "R6");
    tx_list[0] = 12'h801; tx_list[1] = 12'h0F0; tx_list[2] = 12'h3C5;
    tx_list[3] = 12'h002; tx_list[4] = 12'hE77; tx_list[5] = 12'h400;
    t_live_words("R4");
    t_slip();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule